// File: doc/BRIEF.md
# Machine-Mode Trap and CSR Unit

This block keeps the machine-level control and status registers of a small 32-bit core that has two privilege levels, user and machine. When the core raises a trap, the unit does all of the following in one clock edge. It stores the faulting pc. It records why the trap happened and the privilege it came from. It turns off the global interrupt enable. It computes where the handler lives. One cycle later it issues a single-cycle redirect to the fetch stage.

A return strobe reverses the trap in one edge. It restores the privilege and the interrupt enable, and it redirects to the saved pc. While in machine mode, software reaches the six registers through a 12-bit-addressed read/write port. Any access from user mode, or to an unknown address, is refused and flagged. A trap in the same cycle as a register write or a return always takes priority.

Top module: `mtrap_csr_unit`

## Requirements
- R1: After reset, privilege is machine (2'b11), `mie_out` is 0, `redir_vld` is 0, and every register reads 0.
- R2: One cycle after `trap_req`, `redir_vld` is high for exactly that cycle and privilege is machine. The exception-pc register (address 0x341) then reads `trap_pc` with bits [1:0] cleared.
- R3: On a trap, the cause register (0x342) takes `trap_is_irq` in bit 31 and `trap_cause` in its low CAUSE_W bits. All other bits are 0.
- R4: On a trap, the trap-value register (0x343) takes `trap_tval` when `trap_tval_vld` is 1, and 0 otherwise.
- R5: In the status register (0x300), bit 3 is the interrupt enable, bit 7 is the saved enable and bits [12:11] are the saved privilege. On a trap, bit 7 takes the old bit 3, bit 3 is cleared and [12:11] take the old privilege.
- R6: Let base be the vector register (0x305) with bits [1:0] cleared. If its bits [1:0] are 01 and the trap is an interrupt, the redirect goes to base + 4×cause. Otherwise it goes to base.
- R7: On `ret_req` without a trap, the next cycle redirects to the exception-pc value. Privilege takes [12:11], bit 3 takes bit 7, bit 7 becomes 1 and [12:11] become user (00).
- R8: When `trap_req` is high, a simultaneous `ret_req` or CSR write is discarded. A CSR write in the same cycle as `ret_req` is also discarded.
- R9: In machine mode, a write takes effect at the next edge. The scratch (0x340) and trap-value registers keep all 32 bits. The exception-pc register forces bits [1:0] to 0. The vector register forces bit 1 to 0. The cause register keeps bit 31 and the low CAUSE_W bits. A status write of [12:11] other than 11 stores 00.
- R10: `csr_err` is high when a read or write targets an unknown address, or when either happens in user mode. In those cases `csr_rdata` is 0 and no register changes.
- R11: `mie_out` follows status bit 3, and `priv` shows the current level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_is_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | CAUSE_W | Cause code |
| trap_pc | input | 32 | pc of the interrupted instruction |
| trap_tval_vld | input | 1 | Faulting address present |
| trap_tval | input | 32 | Faulting address |
| ret_req | input | 1 | Return-from-trap strobe |
| csr_addr | input | 12 | CSR number |
| csr_ren | input | 1 | CSR read access |
| csr_wen | input | 1 | CSR write access |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational) |
| csr_err | output | 1 | Access refused |
| redir_vld | output | 1 | One-cycle redirect pulse |
| redir_pc | output | 32 | Redirect target |
| priv | output | 2 | Current privilege (00 user, 11 machine) |
| mie_out | output | 1 | Global interrupt enable |

## Verification
Two collisions are tested: a trap together with a CSR write, and a trap together with a return. Directed cycles aim a scratch-register write at a trap cycle, and raise a return and a trap in the same cycle. Random traffic then produces both collisions many more times. The bench model applies the trap and drops the other request. Every register is then read back through the CSR port, and each redirect is compared against the trap target.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam logic [11:0] A_STATUS  = 12'h300;
  localparam logic [11:0] A_TVEC    = 12'h305;
  localparam logic [11:0] A_SCRATCH = 12'h340;
  localparam logic [11:0] A_EPC     = 12'h341;
  localparam logic [11:0] A_CAUSE   = 12'h342;
  localparam logic [11:0] A_TVAL    = 12'h343;

  localparam int B_IE    = 3;
  localparam int B_PIE   = 7;
  localparam int B_PP_LO = 11;

  function automatic logic addr_known(input logic [11:0] a);
    return (a == A_STATUS) || (a == A_TVEC) || (a == A_SCRATCH) ||
           (a == A_EPC) || (a == A_CAUSE) || (a == A_TVAL);
  endfunction

  function automatic logic [31:0] vec_target(input logic [31:0] tvec,
                                             input logic irq,
                                             input logic [31:0] code);
    logic [31:0] base;
    base = {tvec[31:2], 2'b00};
    if (tvec[1:0] == 2'b01 && irq) return base + (code << 2);
    return base;
  endfunction

  function automatic logic [31:0] tvec_legal(input logic [31:0] w);
    return {w[31:2], 1'b0, w[0]};
  endfunction

  function automatic logic [1:0] pp_legal(input logic [1:0] w);
    return (w == PRIV_M) ? PRIV_M : PRIV_U;
  endfunction
endpackage

// File: rtl/mtrap_vector.sv
module mtrap_vector #(
  parameter int CAUSE_W = 5
) (
  input  logic [31:0]        tvec,
  input  logic               is_irq,
  input  logic [CAUSE_W-1:0] cause,
  output logic [31:0]        target
);
  import mtrap_pkg::*;
  localparam int PAD_W = 32 - CAUSE_W;

  always_comb target = vec_target(tvec, is_irq, {{PAD_W{1'b0}}, cause});
endmodule

// File: rtl/mtrap_status.sv
module mtrap_status (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trap_take,
  input  logic        ret_take,
  input  logic        wr_en,
  input  logic        wr_ie,
  input  logic        wr_pie,
  input  logic [1:0]  wr_pp,
  output logic [1:0]  priv,
  output logic        ie,
  output logic        pie,
  output logic [1:0]  pp,
  output logic [31:0] status_word
);
  import mtrap_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv <= PRIV_M;
      ie   <= 1'b0;
      pie  <= 1'b0;
      pp   <= PRIV_U;
    end else if (trap_take) begin
      pie  <= ie;
      ie   <= 1'b0;
      pp   <= priv;
      priv <= PRIV_M;
    end else if (ret_take) begin
      priv <= pp;
      ie   <= pie;
      pie  <= 1'b1;
      pp   <= PRIV_U;
    end else if (wr_en) begin
      ie  <= wr_ie;
      pie <= wr_pie;
      pp  <= pp_legal(wr_pp);
    end
  end

  always_comb begin
    status_word = '0;
    status_word[B_IE] = ie;
    status_word[B_PIE] = pie;
    status_word[B_PP_LO+1:B_PP_LO] = pp;
  end
endmodule

// File: rtl/mtrap_csr_file.sv
module mtrap_csr_file #(
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_take,
  input  logic               trap_is_irq,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [31:0]        trap_pc,
  input  logic               trap_tval_vld,
  input  logic [31:0]        trap_tval,
  input  logic               wr_en,
  input  logic [11:0]        wr_addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        tvec,
  output logic [31:0]        epc,
  output logic [31:0]        cause,
  output logic [31:0]        tval,
  output logic [31:0]        scratch
);
  import mtrap_pkg::*;
  localparam int PAD_W = 31 - CAUSE_W;
  localparam logic [31:0] CAUSE_MASK = {1'b1, {PAD_W{1'b0}}, {CAUSE_W{1'b1}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tvec    <= '0;
      epc     <= '0;
      cause   <= '0;
      tval    <= '0;
      scratch <= '0;
    end else if (trap_take) begin
      epc   <= {trap_pc[31:2], 2'b00};
      cause <= {trap_is_irq, {PAD_W{1'b0}}, trap_cause};
      tval  <= trap_tval_vld ? trap_tval : 32'h0;
    end else if (wr_en) begin
      case (wr_addr)
        A_TVEC:    tvec    <= tvec_legal(wdata);
        A_EPC:     epc     <= {wdata[31:2], 2'b00};
        A_CAUSE:   cause   <= wdata & CAUSE_MASK;
        A_TVAL:    tval    <= wdata;
        A_SCRATCH: scratch <= wdata;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/mtrap_csr_unit.sv
module mtrap_csr_unit #(
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_req,
  input  logic               trap_is_irq,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [31:0]        trap_pc,
  input  logic               trap_tval_vld,
  input  logic [31:0]        trap_tval,
  input  logic               ret_req,
  input  logic [11:0]        csr_addr,
  input  logic               csr_ren,
  input  logic               csr_wen,
  input  logic [31:0]        csr_wdata,
  output logic [31:0]        csr_rdata,
  output logic               csr_err,
  output logic               redir_vld,
  output logic [31:0]        redir_pc,
  output logic [1:0]         priv,
  output logic               mie_out
);
  import mtrap_pkg::*;

  logic        trap_take, ret_take, in_m, known, wr_ok, status_wr;
  logic        ie_q, pie_q;
  logic [1:0]  pp_q;
  logic [31:0] status_q, tvec_q, epc_q, cause_q, tval_q, scratch_q, vec_tgt;

  assign trap_take = trap_req;
  assign ret_take  = ret_req & ~trap_req;
  assign in_m      = (priv == PRIV_M);
  assign known     = addr_known(csr_addr);
  assign wr_ok     = csr_wen & in_m & known & ~trap_req & ~ret_req;
  assign status_wr = wr_ok & (csr_addr == A_STATUS);
  assign csr_err   = (csr_ren | csr_wen) & ~(in_m & known);
  assign mie_out   = ie_q;

  mtrap_status u_status (
    .clk(clk), .rst_n(rst_n), .trap_take(trap_take), .ret_take(ret_take),
    .wr_en(status_wr), .wr_ie(csr_wdata[B_IE]), .wr_pie(csr_wdata[B_PIE]),
    .wr_pp(csr_wdata[B_PP_LO+1:B_PP_LO]),
    .priv(priv), .ie(ie_q), .pie(pie_q), .pp(pp_q), .status_word(status_q)
  );

  mtrap_csr_file #(.CAUSE_W(CAUSE_W)) u_file (
    .clk(clk), .rst_n(rst_n), .trap_take(trap_take), .trap_is_irq(trap_is_irq),
    .trap_cause(trap_cause), .trap_pc(trap_pc), .trap_tval_vld(trap_tval_vld),
    .trap_tval(trap_tval), .wr_en(wr_ok), .wr_addr(csr_addr), .wdata(csr_wdata),
    .tvec(tvec_q), .epc(epc_q), .cause(cause_q), .tval(tval_q), .scratch(scratch_q)
  );

  mtrap_vector #(.CAUSE_W(CAUSE_W)) u_vec (
    .tvec(tvec_q), .is_irq(trap_is_irq), .cause(trap_cause), .target(vec_tgt)
  );

  always_comb begin
    csr_rdata = '0;
    if (in_m) begin
      case (csr_addr)
        A_STATUS:  csr_rdata = status_q;
        A_TVEC:    csr_rdata = tvec_q;
        A_SCRATCH: csr_rdata = scratch_q;
        A_EPC:     csr_rdata = epc_q;
        A_CAUSE:   csr_rdata = cause_q;
        A_TVAL:    csr_rdata = tval_q;
        default:   csr_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_vld <= 1'b0;
      redir_pc  <= '0;
    end else begin
      redir_vld <= trap_take | ret_take;
      redir_pc  <= trap_take ? vec_tgt : epc_q;
    end
  end
endmodule

// File: rtl/mtrap_chk.sv
module mtrap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        trap_req,
  input logic        trap_is_irq,
  input logic        ret_req,
  input logic        csr_ren,
  input logic        csr_wen,
  input logic        csr_err,
  input logic [31:0] csr_rdata,
  input logic        redir_vld,
  input logic [31:0] redir_pc,
  input logic [1:0]  priv,
  input logic        mie_out,
  input logic [31:0] epc_q,
  input logic [31:0] cause_q,
  input logic [31:0] scratch_q,
  input logic        pie_q,
  input logic [1:0]  pp_q
);
  // R2
  redir_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld |-> $past(trap_req || ret_req));
  // R2
  trap_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (redir_vld && priv == 2'b11 && !mie_out));
  // R3
  cause_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (cause_q[31] == $past(trap_is_irq)));
  // R5
  pie_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (pie_q == $past(mie_out)));
  // R7
  ret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !trap_req) |=> (redir_pc == $past(epc_q) && pp_q == 2'b00 && pie_q));
  // R8
  trap_blocks_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && csr_wen) |=> (scratch_q == $past(scratch_q)));
  // R10
  user_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((csr_ren || csr_wen) && priv == 2'b00) |-> (csr_err && csr_rdata == 32'h0));
  // R10
  user_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wen && priv == 2'b00) |=> (scratch_q == $past(scratch_q)));
endmodule

bind mtrap_csr_unit mtrap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_is_irq(trap_is_irq),
  .ret_req(ret_req), .csr_ren(csr_ren), .csr_wen(csr_wen), .csr_err(csr_err),
  .csr_rdata(csr_rdata), .redir_vld(redir_vld), .redir_pc(redir_pc), .priv(priv),
  .mie_out(mie_out), .epc_q(epc_q), .cause_q(cause_q), .scratch_q(scratch_q),
  .pie_q(pie_q), .pp_q(pp_q)
);

// File: tb/sim_mtrap_csr_unit.sv
`timescale 1ns/1ps
module sim_mtrap_csr_unit;
  localparam int CW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, trap_req, trap_is_irq, trap_tval_vld, ret_req, csr_ren, csr_wen;
  logic [CW-1:0] trap_cause;
  logic [31:0] trap_pc, trap_tval, csr_wdata, csr_rdata, redir_pc;
  logic [11:0] csr_addr;
  logic csr_err, redir_vld, mie_out;
  logic [1:0] priv;

  mtrap_csr_unit #(.CAUSE_W(CW)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [1:0] m_priv, m_pp;
  logic m_ie, m_pie, m_vld;
  logic [31:0] m_tvec, m_epc, m_cause, m_tval, m_scr, m_pc;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic known(logic [11:0] a);
    return a == 12'h300 || a == 12'h305 || (a >= 12'h340 && a <= 12'h343);
  endfunction

  function automatic logic [31:0] status_of();
    return (32'(m_pp) << 11) | (32'(m_pie) << 7) | (32'(m_ie) << 3);
  endfunction

  function automatic logic [31:0] model_read(logic [11:0] a);
    if (m_priv != 2'b11) return 0;
    case (a)
      12'h300: return status_of();
      12'h305: return m_tvec;
      12'h340: return m_scr;
      12'h341: return m_epc;
      12'h342: return m_cause;
      12'h343: return m_tval;
      default: return 0;
    endcase
  endfunction

  // handler address, restated: offset only for vectored interrupts
  function automatic logic [31:0] handler(logic [31:0] tv, logic irq, logic [CW-1:0] c);
    logic [31:0] off;
    off = (tv[0] && !tv[1] && irq) ? 32'(c) * 4 : 32'h0;
    return (tv & 32'hFFFF_FFFC) + off;
  endfunction

  task automatic idle();
    trap_req = 0; trap_is_irq = 0; trap_cause = '0; trap_pc = '0;
    trap_tval_vld = 0; trap_tval = '0; ret_req = 0;
    csr_addr = 12'h300; csr_ren = 0; csr_wen = 0; csr_wdata = '0;
  endtask

  // called at posedge+1 with inputs set; ends at next posedge+1
  task automatic apply();
    logic [31:0] w;
    #1;
    chk((m_priv == 2'b11) ? "R9" : "R10", csr_rdata, model_read(csr_addr));
    chk("R10", 32'(csr_err), 32'((csr_ren | csr_wen) & ((m_priv != 2'b11) | !known(csr_addr))));
    m_vld = 0;
    w = csr_wdata;
    if (trap_req) begin
      m_pc = handler(m_tvec, trap_is_irq, trap_cause);
      m_vld = 1;
      m_epc = trap_pc & 32'hFFFF_FFFC;
      m_cause = (32'(trap_is_irq) << 31) | 32'(trap_cause);
      m_tval = trap_tval_vld ? trap_tval : 0;
      m_pie = m_ie; m_ie = 0; m_pp = m_priv; m_priv = 2'b11;
    end else if (ret_req) begin
      m_pc = m_epc; m_vld = 1;
      m_priv = m_pp; m_ie = m_pie; m_pie = 1; m_pp = 2'b00;
    end else if (csr_wen && m_priv == 2'b11) begin
      case (csr_addr)
        12'h300: begin m_ie = w[3]; m_pie = w[7]; m_pp = (w[12:11] == 2'b11) ? 2'b11 : 2'b00; end
        12'h305: m_tvec = w & 32'hFFFF_FFFD;
        12'h340: m_scr = w;
        12'h341: m_epc = w & ~32'h3;
        12'h342: m_cause = w & 32'h8000_001F;
        12'h343: m_tval = w;
        default: ;
      endcase
    end
    @(posedge clk); #1;
    chk("R2", 32'(redir_vld), 32'(m_vld));
    if (m_vld) chk(trap_req ? "R6" : "R7", redir_pc, m_pc);
    chk("R11", 32'(priv), 32'(m_priv));
    chk("R11", 32'(mie_out), 32'(m_ie));
    idle();
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    idle(); csr_wen = 1; csr_addr = a; csr_wdata = d; apply();
  endtask

  task automatic trap(logic irq, logic [CW-1:0] c, logic [31:0] pc, logic tv_v, logic [31:0] tv);
    idle(); trap_req = 1; trap_is_irq = irq; trap_cause = c; trap_pc = pc;
    trap_tval_vld = tv_v; trap_tval = tv; apply();
  endtask

  task automatic rd_chk(logic [11:0] a, logic [31:0] exp, string tag);
    idle(); csr_ren = 1; csr_addr = a; #1;
    chk(tag, csr_rdata, exp);
    @(posedge clk); #1; idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle(); rst_n = 0;
    m_priv = 2'b11; m_pp = 0; m_ie = 0; m_pie = 0; m_vld = 0;
    m_tvec = 0; m_epc = 0; m_cause = 0; m_tval = 0; m_scr = 0; m_pc = 0;
    repeat (3) @(posedge clk); #1;
    chk("R1", 32'(priv), 32'h3);
    chk("R1", 32'(mie_out), 0);
    chk("R1", 32'(redir_vld), 0);
    rst_n = 1;
    foreach (m_tvec[i]) if (i < 6) rd_chk((i < 2) ? 12'h300 + 12'(5 * i) : 12'h33E + 12'(i), 0, "R1");

    // vectored base, scratch, enable interrupts
    wr(12'h305, 32'h0000_1003);
    rd_chk(12'h305, 32'h0000_1001, "R9");
    wr(12'h340, 32'hA5A5_0001);
    wr(12'h300, 32'h0000_0008);
    // R8: trap with simultaneous scratch write; R6: vectored max cause
    idle(); trap_req = 1; trap_is_irq = 1; trap_cause = 5'd31; trap_pc = 32'h0000_0403;
    csr_wen = 1; csr_addr = 12'h340; csr_wdata = 32'hDEAD_BEEF; apply();
    chk("R6", redir_pc, 32'h0000_107C);
    rd_chk(12'h340, 32'hA5A5_0001, "R8");
    rd_chk(12'h342, 32'h8000_001F, "R3");
    rd_chk(12'h341, 32'h0000_0400, "R2");
    rd_chk(12'h300, 32'h0000_1880, "R5");
    rd_chk(12'h343, 0, "R4");
    // exception in vectored mode goes to base
    trap(0, 5'd13, 32'h0000_2000, 1, 32'hBEEF_0000);
    chk("R6", redir_pc, 32'h0000_1000);
    rd_chk(12'h343, 32'hBEEF_0000, "R4");
    rd_chk(12'h342, 32'h0000_000D, "R3");
    // return to machine
    idle(); ret_req = 1; apply();
    chk("R7", redir_pc, 32'h0000_2000);
    // R9 legalisation
    wr(12'h341, 32'h0000_0123);
    rd_chk(12'h341, 32'h0000_0120, "R9");
    wr(12'h300, 32'h0000_0888);
    rd_chk(12'h300, 32'h0000_0088, "R9");
    // drop to user mode
    idle(); ret_req = 1; apply();
    chk("R7", 32'(priv), 0);
    idle(); csr_wen = 1; csr_addr = 12'h340; csr_wdata = 32'h1111_1111; apply();
    rd_chk(12'h340, 0, "R10");
    // trap and return together: trap wins, back to machine
    idle(); trap_req = 1; ret_req = 1; trap_cause = 5'd2; trap_pc = 32'h0000_3000; apply();
    chk("R8", redir_pc, 32'h0000_1000);
    rd_chk(12'h340, 32'hA5A5_0001, "R10");
    rd_chk(12'h300, 32'h0000_0080, "R5");

    for (int k = 0; k < 4000; k++) begin
      int r;
      idle();
      r = int'($urandom % 100);
      trap_req = (r < 12); ret_req = (r >= 8 && r < 20);
      trap_is_irq = $urandom; trap_cause = CW'($urandom);
      trap_pc = $urandom; trap_tval_vld = $urandom; trap_tval = $urandom;
      csr_ren = $urandom; csr_wen = ($urandom % 100) < 45;
      case ($urandom % 7)
        0: csr_addr = 12'h300; 1: csr_addr = 12'h305; 2: csr_addr = 12'h340;
        3: csr_addr = 12'h341; 4: csr_addr = 12'h342; 5: csr_addr = 12'h343;
        default: csr_addr = 12'h7C0;
      endcase
      csr_wdata = $urandom;
      apply();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule